// File: doc/BRIEF.md
# Four-Valued Controlled-Gate Stage

This block is one combinational stage of a cascade that models a reversible circuit built from two-wire controlled gates. Every wire carries one of four symbolic values: the two basis values 0 and 1, and the two half-turn values V0 and V1 that a square-root-of-NOT leaves behind. No complex amplitudes are computed. The values form a small closed algebra, so each gate is a fixed four-entry mapping.

A stage receives the whole wire vector and a gate selection. The selection is a gate code, the index of the control wire and the index of the data wire. The stage applies the gate to the data wire when the control wire holds basis 1, and passes every other wire through untouched. A sticky error flag travels with the vector. It is raised when a gate's control wire holds a non-basis value, because such a gate would leave the wires entangled and outside the algebra. A separate configuration-error output rejects selections that cannot be built. Stages are chained by wiring the wire vector and the flag of one stage into the next.

Top module: `qstage_top`

## Requirements
- R1: Each wire uses two bits, encoded 2'b00 = 0, 2'b01 = 1, 2'b10 = V0, 2'b11 = V1, with wire k at bits [2k+1:2k]. When the configuration is valid and the control wire holds 0, the whole vector and the flag pass through unchanged.
- R2: Gate code 3'd0 (controlled-NOT) with control 1 maps the data wire 0→1, 1→0, V0→V1, V1→V0.
- R3: Gate code 3'd1 (controlled-root) with control 1 maps the data wire 0→V0, 1→V1, V0→1, V1→0.
- R4: Gate code 3'd2 (controlled-inverse-root) with control 1 maps the data wire 0→V1, 1→V0, V0→0, V1→1.
- R5: Gate codes 3'd3 to 3'd6 are merged pairs applied in sequence on the same two wires, gated by the control value seen before the first step. 3'd3 is NOT then root, 3'd4 is NOT then inverse-root, 3'd5 is root then NOT, and 3'd6 is inverse-root then NOT.
- R6: Every wire other than the data wire leaves the stage with its input value.
- R7: With a valid configuration and a control wire holding V0 or V1, the outgoing error flag is 1 and the wire vector passes through unchanged.
- R8: An incoming error flag of 1 always gives an outgoing flag of 1.
- R9: Gate code 3'd7, an index of NUM_WIRES or above, or equal control and data indices raise the configuration-error output. In that case the vector passes through unchanged and the outgoing flag equals the incoming flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wiresIn | input | 2*NUM_WIRES | Incoming wire vector, two bits per wire |
| gateSel | input | 3 | Gate code |
| ctrlIdx | input | IDX_W | Index of the control wire |
| dataIdx | input | IDX_W | Index of the data wire |
| errIn | input | 1 | Incoming sticky error flag |
| wiresOut | output | 2*NUM_WIRES | Updated wire vector |
| errOut | output | 1 | Outgoing sticky error flag |
| cfgErr | output | 1 | Configuration rejected |

## Verification
The bench builds the stage with NUM_WIRES = 3. That gives two-bit indices in which the value 3 lies out of range, so the range check of R9 is exercised alongside the equal-index and invalid-code cases. Three wires keep the full input space small: every wire vector, every gate code, every index pair and both flag values come to 16384 vectors, and all of them are applied. This covers every control and data value in every position, with one bystander wire always present to check R6.

// File: rtl/qstage_pkg.sv
package qstage_pkg;

  typedef enum logic [1:0] {
    QV_ZERO = 2'b00,
    QV_ONE  = 2'b01,
    QV_V0   = 2'b10,
    QV_V1   = 2'b11
  } qval_e;

  typedef enum logic [1:0] {
    OP_PASS,
    OP_FLIP,
    OP_ROOT,
    OP_ROOTINV
  } qop_e;

  typedef struct packed {
    qop_e firstOp;
    qop_e secondOp;
    logic cfgBad;
  } stageCtrl_t;

  function automatic qval_e applyOp(qop_e op, qval_e v);
    qval_e r;
    r = v;
    unique case (op)
      OP_PASS: r = v;
      OP_FLIP: begin
        unique case (v)
          QV_ZERO: r = QV_ONE;
          QV_ONE:  r = QV_ZERO;
          QV_V0:   r = QV_V1;
          QV_V1:   r = QV_V0;
        endcase
      end
      OP_ROOT: begin
        unique case (v)
          QV_ZERO: r = QV_V0;
          QV_ONE:  r = QV_V1;
          QV_V0:   r = QV_ONE;
          QV_V1:   r = QV_ZERO;
        endcase
      end
      OP_ROOTINV: begin
        unique case (v)
          QV_ZERO: r = QV_V1;
          QV_ONE:  r = QV_V0;
          QV_V0:   r = QV_ZERO;
          QV_V1:   r = QV_ONE;
        endcase
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/qstage_ctrl.sv
module qstage_ctrl
  import qstage_pkg::*;
#(
  parameter int NUM_WIRES = 4,
  parameter int IDX_W     = $clog2(NUM_WIRES)
) (
  input  logic [2:0]       gateSel,
  input  logic [IDX_W-1:0] ctrlIdx,
  input  logic [IDX_W-1:0] dataIdx,
  output stageCtrl_t       strobes
);

  logic ctrlOutOfRange;
  logic dataOutOfRange;
  logic sameWire;
  logic badCode;

  always_comb begin
    ctrlOutOfRange = 32'(ctrlIdx) >= NUM_WIRES;
    dataOutOfRange = 32'(dataIdx) >= NUM_WIRES;
    sameWire       = ctrlIdx == dataIdx;
    badCode        = gateSel == 3'd7;
  end

  always_comb begin
    strobes.firstOp  = OP_PASS;
    strobes.secondOp = OP_PASS;
    unique case (gateSel)
      3'd0: strobes.firstOp = OP_FLIP;
      3'd1: strobes.firstOp = OP_ROOT;
      3'd2: strobes.firstOp = OP_ROOTINV;
      3'd3: begin strobes.firstOp = OP_FLIP;    strobes.secondOp = OP_ROOT;    end
      3'd4: begin strobes.firstOp = OP_FLIP;    strobes.secondOp = OP_ROOTINV; end
      3'd5: begin strobes.firstOp = OP_ROOT;    strobes.secondOp = OP_FLIP;    end
      3'd6: begin strobes.firstOp = OP_ROOTINV; strobes.secondOp = OP_FLIP;    end
      default: ;
    endcase
    strobes.cfgBad = badCode | ctrlOutOfRange | dataOutOfRange | sameWire;
  end

endmodule

// File: rtl/qstage_dp.sv
module qstage_dp
  import qstage_pkg::*;
#(
  parameter int NUM_WIRES = 4,
  parameter int IDX_W     = $clog2(NUM_WIRES),
  parameter int VEC_W     = 2 * NUM_WIRES
) (
  input  logic [VEC_W-1:0] wiresIn,
  input  logic [IDX_W-1:0] ctrlIdx,
  input  logic [IDX_W-1:0] dataIdx,
  input  logic             errIn,
  input  stageCtrl_t       strobes,
  output logic [VEC_W-1:0] wiresOut,
  output logic             errOut
);

  qval_e lanes [NUM_WIRES];
  qval_e ctrlVal;
  logic  gateFires;

  for (genvar k = 0; k < NUM_WIRES; k++) begin : g_unpack
    assign lanes[k] = qval_e'(wiresIn[2*k +: 2]);
  end

  always_comb begin
    ctrlVal = QV_ZERO;
    for (int k = 0; k < NUM_WIRES; k++) begin
      if (ctrlIdx == IDX_W'(k)) ctrlVal = lanes[k];
    end
  end

  assign gateFires = !strobes.cfgBad && (ctrlVal == QV_ONE);
  assign errOut    = errIn | (!strobes.cfgBad && ctrlVal[1]);

  for (genvar k = 0; k < NUM_WIRES; k++) begin : g_lane
    qval_e stepOne;
    qval_e stepTwo;
    logic  isTarget;
    always_comb begin
      isTarget = gateFires && (dataIdx == IDX_W'(k));
      stepOne  = applyOp(strobes.firstOp, lanes[k]);
      stepTwo  = applyOp(strobes.secondOp, stepOne);
    end
    assign wiresOut[2*k +: 2] = isTarget ? stepTwo : lanes[k];
  end

endmodule

// File: rtl/qstage_top.sv
module qstage_top
  import qstage_pkg::*;
#(
  parameter int NUM_WIRES = 4,
  localparam int IDX_W    = $clog2(NUM_WIRES),
  localparam int VEC_W    = 2 * NUM_WIRES
) (
  input  logic [VEC_W-1:0] wiresIn,
  input  logic [2:0]       gateSel,
  input  logic [IDX_W-1:0] ctrlIdx,
  input  logic [IDX_W-1:0] dataIdx,
  input  logic             errIn,
  output logic [VEC_W-1:0] wiresOut,
  output logic             errOut,
  output logic             cfgErr
);

  stageCtrl_t strobes;

  qstage_ctrl #(.NUM_WIRES(NUM_WIRES), .IDX_W(IDX_W)) ctrl_i (
    .gateSel (gateSel),
    .ctrlIdx (ctrlIdx),
    .dataIdx (dataIdx),
    .strobes (strobes)
  );

  qstage_dp #(.NUM_WIRES(NUM_WIRES), .IDX_W(IDX_W), .VEC_W(VEC_W)) dp_i (
    .wiresIn  (wiresIn),
    .ctrlIdx  (ctrlIdx),
    .dataIdx  (dataIdx),
    .errIn    (errIn),
    .strobes  (strobes),
    .wiresOut (wiresOut),
    .errOut   (errOut)
  );

  assign cfgErr = strobes.cfgBad;

endmodule

// File: rtl/qstage_chk.sv
module qstage_chk #(
  parameter int NUM_WIRES = 4,
  parameter int IDX_W     = $clog2(NUM_WIRES),
  parameter int VEC_W     = 2 * NUM_WIRES
) (
  input logic [VEC_W-1:0] wiresIn,
  input logic [2:0]       gateSel,
  input logic [IDX_W-1:0] ctrlIdx,
  input logic [IDX_W-1:0] dataIdx,
  input logic             errIn,
  input logic [VEC_W-1:0] wiresOut,
  input logic             errOut,
  input logic             cfgErr
);

  logic [1:0] ctrlLane;

  always_comb begin
    ctrlLane = 2'b00;
    for (int k = 0; k < NUM_WIRES; k++) begin
      if (ctrlIdx == IDX_W'(k)) ctrlLane = wiresIn[2*k +: 2];
    end
  end

  always_comb begin
    if (errIn) begin
      assert_sticky_flag_R8: assert (errOut);
    end
    if (cfgErr) begin
      assert_cfg_hold_R9: assert (wiresOut == wiresIn && errOut == errIn);
    end
    if (!cfgErr && ctrlLane == 2'b00) begin
      assert_ctrl_zero_pass_R1: assert (wiresOut == wiresIn && errOut == errIn);
    end
    if (!cfgErr && ctrlLane[1]) begin
      assert_nonbasis_flag_R7: assert (errOut && wiresOut == wiresIn);
    end
    for (int k = 0; k < NUM_WIRES; k++) begin
      if (dataIdx != IDX_W'(k)) begin
        assert_bystander_R6: assert (wiresOut[2*k +: 2] == wiresIn[2*k +: 2]);
      end
    end
  end

endmodule

bind qstage_top qstage_chk #(.NUM_WIRES(NUM_WIRES)) chk_i (
  .wiresIn  (wiresIn),
  .gateSel  (gateSel),
  .ctrlIdx  (ctrlIdx),
  .dataIdx  (dataIdx),
  .errIn    (errIn),
  .wiresOut (wiresOut),
  .errOut   (errOut),
  .cfgErr   (cfgErr)
);

// File: tb/qstage_top_tb_top.sv
module qstage_top_tb_top;

  localparam int NW    = 3;
  localparam int IW    = $clog2(NW);
  localparam int VW    = 2 * NW;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [VW-1:0] wiresIn;
  logic [2:0]    gateSel;
  logic [IW-1:0] ctrlIdx;
  logic [IW-1:0] dataIdx;
  logic          errIn;
  logic [VW-1:0] wiresOut;
  logic          errOut;
  logic          cfgErr;

  int  nChecks = 0;
  int  nFails  = 0;
  int  cycles  = 0;
  bit  done    = 1'b0;

  qstage_top #(.NUM_WIRES(NW)) dut_i (
    .wiresIn  (wiresIn),
    .gateSel  (gateSel),
    .ctrlIdx  (ctrlIdx),
    .dataIdx  (dataIdx),
    .errIn    (errIn),
    .wiresOut (wiresOut),
    .errOut   (errOut),
    .cfgErr   (cfgErr)
  );

  // Values as quarter turns about the basis circle: 0 -> 0, V0 -> 1, 1 -> 2, V1 -> 3.
  function automatic int toTurn(logic [1:0] e);
    return (e == 2'b00) ? 0 : (e == 2'b10) ? 1 : (e == 2'b01) ? 2 : 3;
  endfunction

  function automatic logic [1:0] fromTurn(int t);
    int m = t % 4;
    return (m == 0) ? 2'b00 : (m == 1) ? 2'b10 : (m == 2) ? 2'b01 : 2'b11;
  endfunction

  // NOT = two quarter turns, root = +1, inverse root = +3.
  function automatic int gateTurns(int g);
    int stepA = 0;
    int stepB = 0;
    case (g)
      0: stepA = 2;
      1: stepA = 1;
      2: stepA = 3;
      3: begin stepA = 2; stepB = 1; end
      4: begin stepA = 2; stepB = 3; end
      5: begin stepA = 1; stepB = 2; end
      6: begin stepA = 3; stepB = 2; end
      default: ;
    endcase
    return stepA + stepB;
  endfunction

  task automatic applyAndCheck(int w, int g, int c, int d, int e);
    logic [VW-1:0] expVec;
    logic          expErr;
    logic          expCfg;
    logic [1:0]    cv;
    string         tag;
    @(posedge clk);
    wiresIn = VW'(w);
    gateSel = 3'(g);
    ctrlIdx = IW'(c);
    dataIdx = IW'(d);
    errIn   = 1'(e);
    expCfg = (g == 7) || (c >= NW) || (d >= NW) || (c == d);
    expVec = VW'(w);
    expErr = 1'(e);
    cv     = (c < NW) ? 2'((w >> (2 * c)) & 3) : 2'b00;
    if (expCfg) tag = "R9";
    else if (cv == 2'b00) tag = "R1";
    else if (cv[1]) begin
      expErr = 1'b1;
      tag = "R7";
    end else begin
      expVec[2*d +: 2] = fromTurn(toTurn(expVec[2*d +: 2]) + gateTurns(g));
      tag = (g == 0) ? "R2" : (g == 1) ? "R3" : (g == 2) ? "R4" : "R5";
    end
    if (e != 0) tag = {tag, ",R8"};
    tag = {tag, ",R6"};
    @(negedge clk);
    nChecks++;
    if (wiresOut !== expVec || errOut !== expErr || cfgErr !== expCfg) begin
      nFails++;
      $display("FAIL %s w=%0h g=%0d c=%0d d=%0d e=%0d: got vec=%0h err=%0b cfg=%0b exp vec=%0h err=%0b cfg=%0b",
               tag, w, g, c, d, e, wiresOut, errOut, cfgErr, expVec, expErr, expCfg);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > LIMIT) begin
      nFails++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    wiresIn = '0;
    gateSel = '0;
    ctrlIdx = '0;
    dataIdx = '0;
    errIn   = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle vector first: all wires 0, flags clear (R1).
    applyAndCheck(0, 0, 1, 0, 0);
    for (int e = 0; e < 2; e++)
      for (int g = 0; g < 8; g++)
        for (int c = 0; c < (1 << IW); c++)
          for (int d = 0; d < (1 << IW); d++)
            for (int w = 0; w < (1 << VW); w++)
              applyAndCheck(w, g, c, d, e);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule